// File: doc/BRIEF.md
# Half-Bridge Fault Management Controller

This block is the central decision logic of a half-bridge gate driver. It takes the already conditioned high-side and low-side gate requests and the desaturation flags from both output channels. It also takes the soft-shutdown completion pulses, the two supply undervoltage flags and a fault-clear input. From these it produces the final on/off command for each channel and the soft-shutdown enable for each channel.

The block shares two active-low wired-OR lines with the other phase drivers and the system controller. The first is a sync line. It is held low while a local soft-shutdown runs, and when another driver pulls it low, this block freezes its outputs. The second is a fault line. It carries local diagnostics, either a latched fault after soft-shutdown or a live undervoltage on the low-side supply. When something else pulls it low, it acts as an external hard-shutdown command. Each line is modelled as a drive-enable output (1 pulls the line low) and a sensed-level input (1 means the line is high). A state code is exposed for observation.

All outputs are registered. A change on the inputs shows on the outputs after the next rising clock edge.

Top module: `hb_fault_ctrl`

## Requirements
- R1: In normal operation, hi_on_o becomes hi_req_i & ~lo_req_i and lo_on_o becomes lo_req_i & ~hi_req_i one clock after the requests. The two outputs are never high together.
- R2: A desat flag on a channel whose output is on starts soft-shutdown on that channel in the next cycle. That channel's output goes low and its ssd_*_o goes high. sync_drive_o is high while any channel is in soft-shutdown. A desat flag on a channel that is off has no effect.
- R3: The sync line drive is released by itself in the cycle after the last soft-shutdown completion pulse. No fault clear is needed.
- R4: When soft-shutdown ends, a fault is latched. fault_drive_o goes high and both outputs stay low until flt_clr_i is seen high outside soft-shutdown. The outputs then follow the requests from the next cycle.
- R5: When sync_sense_i is low and no local soft-shutdown, latched fault, low-side undervoltage or external shutdown applies, both outputs keep their previous values whatever the requests.
- R6: Desat detection still starts soft-shutdown while the outputs are frozen.
- R7: While uv_low_i is high outside soft-shutdown, fault_drive_o is high and both outputs are low. Once uv_low_i falls, the drive is released in the next cycle with no clear.
- R8: When fault_sense_i is low while this block is not driving the line, both outputs go low. flt_clr_i has no effect on this, and the condition is not latched.
- R9: During soft-shutdown, uv_low_i and the external shutdown are masked: fault_drive_o stays low. The channel that is not in soft-shutdown keeps its value whatever its request.
- R10: While uv_float_i is high, hi_on_o is low and lo_on_o follows lo_req_i. No diagnostic is driven on the fault line.
- R11: After uv_float_i falls, hi_on_o stays low until hi_req_i shows a fresh rising edge.
- R12: A low on the fault line caused by this block's own drive is not taken as an external shutdown. After an undervoltage ends, the outputs follow the requests in that same cycle.
- R13: state_o encodes the governing condition with this priority, highest first: 6 soft-shutdown, 5 latched fault, 4 low-side undervoltage, 3 external shutdown, 2 freeze, 1 floating undervoltage, 0 normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hi_req_i | input | 1 | Conditioned high-side request |
| lo_req_i | input | 1 | Conditioned low-side request |
| desat_hi_i | input | 1 | High-side desaturation flag |
| desat_lo_i | input | 1 | Low-side desaturation flag |
| ssd_done_hi_i | input | 1 | High-side soft-shutdown finished pulse |
| ssd_done_lo_i | input | 1 | Low-side soft-shutdown finished pulse |
| uv_low_i | input | 1 | Low-side supply undervoltage |
| uv_float_i | input | 1 | Floating supply undervoltage |
| flt_clr_i | input | 1 | Latched fault clear, active high |
| sync_sense_i | input | 1 | Sensed sync line level (0 = low) |
| fault_sense_i | input | 1 | Sensed fault line level (0 = low) |
| hi_on_o | output | 1 | High-side gate command |
| lo_on_o | output | 1 | Low-side gate command |
| ssd_hi_o | output | 1 | High-side soft-shutdown enable |
| ssd_lo_o | output | 1 | Low-side soft-shutdown enable |
| sync_drive_o | output | 1 | Pull sync line low |
| fault_drive_o | output | 1 | Pull fault line low |
| state_o | output | 3 | Governing condition code |

## Verification
The hardest situations to reach from the ports are those that depend on a soft-shutdown already running. Two cases stand out: undervoltage or an external shutdown arriving mid-sequence, and desat arriving under freeze. Each needs a channel first turned on, then desaturated, and only then the masking stimulus. Directed sequences build these chains step by step, and a seeded random phase follows. In that phase, desat flags on live channels and completion pulses are rare, so sequences last long enough to overlap the other events. The bench models both wired lines by ORing its own external pulls with the block's drives.

// File: rtl/hb_fault_pkg.sv
package hb_fault_pkg;
  localparam int NCH = 2;   // channel 0 = high side, 1 = low side
  localparam int CH_HI = 0;
  localparam int CH_LO = 1;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_NORM = 3'd0,
    ST_UVF  = 3'd1,
    ST_FRZ  = 3'd2,
    ST_EXT  = 3'd3,
    ST_UVL  = 3'd4,
    ST_FLT  = 3'd5,
    ST_SSD  = 3'd6
  } hb_state_e;
endpackage

// File: rtl/hb_ssd_track.sv
module hb_ssd_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_on_i,
  input  logic desat_i,
  input  logic done_i,
  output logic ssd_next_o,
  output logic ssd_o
);
  logic ssd_q;

  // desat is only eligible while the channel drives its gate
  assign ssd_next_o = (ssd_q & ~done_i) | (desat_i & out_on_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ssd_q <= 1'b0;
    else         ssd_q <= ssd_next_o;
  end

  assign ssd_o = ssd_q;

  p_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desat_i && out_on_i) |=> ssd_q);
  p_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ssd_q && done_i && !out_on_i) |=> !ssd_q);
endmodule

// File: rtl/hb_float_guard.sv
module hb_float_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_float_i,
  input  logic hi_req_i,
  output logic block_next_o
);
  logic block_q, req_q;

  always_comb begin
    if (uv_float_i)              block_next_o = 1'b1;
    else if (hi_req_i && !req_q) block_next_o = 1'b0;
    else                         block_next_o = block_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      block_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      block_q <= block_next_o;
      req_q   <= hi_req_i;
    end
  end

  p_rearm_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_q && !uv_float_i && !(hi_req_i && !req_q)) |=> block_q);
endmodule

// File: rtl/hb_arbiter.sv
module hb_arbiter
  import hb_fault_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NCH-1:0]      req_i,
  input  logic [NCH-1:0]      ssd_next_i,
  input  logic [NCH-1:0]      ssd_q_i,
  input  logic                flt_clr_i,
  input  logic                uv_low_i,
  input  logic                uv_float_i,
  input  logic                block_next_i,
  input  logic                sync_sense_i,
  input  logic                fault_sense_i,
  output logic [NCH-1:0]      on_o,
  output logic                fault_drive_o,
  output logic [ST_W-1:0]     state_o
);
  logic [NCH-1:0] on_q, on_n;
  logic           latch_q, latch_n, fdrv_q, fdrv_n;
  logic           act_q, act_n, ssd_end, ext_sd;
  hb_state_e      st_q, st_n;

  assign act_q   = |ssd_q_i;
  assign act_n   = |ssd_next_i;
  assign ssd_end = act_q & ~act_n;
  // line low while not self-driven means another party commands shutdown
  assign ext_sd  = ~fault_sense_i & ~fdrv_q;

  always_comb begin
    if (ssd_end)                   latch_n = 1'b1;
    else if (flt_clr_i && !act_q)  latch_n = 1'b0;
    else                           latch_n = latch_q;
  end

  assign fdrv_n = latch_n | (uv_low_i & ~act_n);

  always_comb begin
    on_n = '0;
    st_n = ST_NORM;
    if (act_n) begin
      st_n = ST_SSD;
      for (int c = 0; c < NCH; c++) on_n[c] = ssd_next_i[c] ? 1'b0 : on_q[c];
    end else if (latch_n) begin
      st_n = ST_FLT;
    end else if (uv_low_i) begin
      st_n = ST_UVL;
    end else if (ext_sd) begin
      st_n = ST_EXT;
    end else if (!sync_sense_i) begin
      st_n = ST_FRZ;
      on_n = on_q;
    end else if (uv_float_i) begin
      st_n = ST_UVF;
      on_n[CH_LO] = req_i[CH_LO];
    end else begin
      on_n[CH_HI] = req_i[CH_HI] & ~req_i[CH_LO] & ~block_next_i;
      on_n[CH_LO] = req_i[CH_LO] & ~req_i[CH_HI];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q    <= '0;
      latch_q <= 1'b0;
      fdrv_q  <= 1'b0;
      st_q    <= ST_NORM;
    end else begin
      on_q    <= on_n;
      latch_q <= latch_n;
      fdrv_q  <= fdrv_n;
      st_q    <= st_n;
    end
  end

  assign on_o          = on_q;
  assign fault_drive_o = fdrv_q;
  assign state_o       = st_q;

  p_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(on_q[CH_HI] && on_q[CH_LO]));
  p_latch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !flt_clr_i) |=> (latch_q && fdrv_q && on_q == '0));
  p_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_sense_i && !act_n && !latch_n && !uv_low_i && !ext_sd) |=> on_q == $past(on_q));
  p_uvl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_low_i && !act_n) |=> (fdrv_q && on_q == '0));
  p_ext_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_sense_i && !fdrv_q && !act_n) |=> on_q == '0);
  p_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_n && !latch_q) |=> !fdrv_q);
  p_uvf_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_float_i && sync_sense_i && !act_n) |=> !on_q[CH_HI]);
endmodule

// File: rtl/hb_fault_ctrl.sv
module hb_fault_ctrl
  import hb_fault_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hi_req_i,
  input  logic            lo_req_i,
  input  logic            desat_hi_i,
  input  logic            desat_lo_i,
  input  logic            ssd_done_hi_i,
  input  logic            ssd_done_lo_i,
  input  logic            uv_low_i,
  input  logic            uv_float_i,
  input  logic            flt_clr_i,
  input  logic            sync_sense_i,
  input  logic            fault_sense_i,
  output logic            hi_on_o,
  output logic            lo_on_o,
  output logic            ssd_hi_o,
  output logic            ssd_lo_o,
  output logic            sync_drive_o,
  output logic            fault_drive_o,
  output logic [ST_W-1:0] state_o
);
  logic [NCH-1:0] req, desat, done, on, ssd_n, ssd_q;
  logic           block_n;

  assign req   = {lo_req_i, hi_req_i};
  assign desat = {desat_lo_i, desat_hi_i};
  assign done  = {ssd_done_lo_i, ssd_done_hi_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hb_ssd_track u_trk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .out_on_i   (on[c]),
      .desat_i    (desat[c]),
      .done_i     (done[c]),
      .ssd_next_o (ssd_n[c]),
      .ssd_o      (ssd_q[c])
    );
  end

  hb_float_guard u_guard (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .uv_float_i   (uv_float_i),
    .hi_req_i     (hi_req_i),
    .block_next_o (block_n)
  );

  hb_arbiter u_arb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req),
    .ssd_next_i    (ssd_n),
    .ssd_q_i       (ssd_q),
    .flt_clr_i     (flt_clr_i),
    .uv_low_i      (uv_low_i),
    .uv_float_i    (uv_float_i),
    .block_next_i  (block_n),
    .sync_sense_i  (sync_sense_i),
    .fault_sense_i (fault_sense_i),
    .on_o          (on),
    .fault_drive_o (fault_drive_o),
    .state_o       (state_o)
  );

  assign hi_on_o      = on[CH_HI];
  assign lo_on_o      = on[CH_LO];
  assign ssd_hi_o     = ssd_q[CH_HI];
  assign ssd_lo_o     = ssd_q[CH_LO];
  assign sync_drive_o = |ssd_q;

  p_ssd_gate_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ssd_hi_o |-> !hi_on_o) and (ssd_lo_o |-> !lo_on_o));
  p_sync_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_drive_o) |-> fault_drive_o);
endmodule

// File: tb/hb_fault_ctrl_test.sv
`timescale 1ns/1ps
module hb_fault_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hr = 0, lr = 0, dh = 0, dl = 0, dnh = 0, dnl = 0;
  logic uvl = 0, uvf = 0, clr = 0, xs = 0, xf = 0;
  logic hi_on, lo_on, ssd_hi, ssd_lo, sync_drv, flt_drv;
  logic [2:0] st;
  logic sync_sense, fault_sense;
  int errors = 0, checks = 0;

  // model state
  logic m_hi = 0, m_lo = 0, m_sh = 0, m_sl = 0, m_lat = 0, m_blk = 0, m_hq = 0, m_fd = 0;
  int   m_st = 0;

  always #2.5 clk = ~clk;

  assign sync_sense  = ~(sync_drv | xs);
  assign fault_sense = ~(flt_drv | xf);

  hb_fault_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .hi_req_i(hr), .lo_req_i(lr),
    .desat_hi_i(dh), .desat_lo_i(dl), .ssd_done_hi_i(dnh), .ssd_done_lo_i(dnl),
    .uv_low_i(uvl), .uv_float_i(uvf), .flt_clr_i(clr),
    .sync_sense_i(sync_sense), .fault_sense_i(fault_sense),
    .hi_on_o(hi_on), .lo_on_o(lo_on), .ssd_hi_o(ssd_hi), .ssd_lo_o(ssd_lo),
    .sync_drive_o(sync_drv), .fault_drive_o(flt_drv), .state_o(st));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string st_tag(input int s);
    case (s)
      0: return "R1 normal";
      1: return "R10 float-uv";
      2: return "R5 freeze";
      3: return "R8 ext-shutdown";
      4: return "R7 low-uv";
      5: return "R4 latched";
      default: return "R2 soft-shutdown";
    endcase
  endfunction

  task automatic mstep();
    logic fs, ss, sh_n, sl_n, act_q, act_n, lat_n, blk_n, ext, h_n, l_n;
    int s;
    fs = ~(m_fd | xf);
    ss = ~(m_sh | m_sl | xs);
    sh_n = (m_sh & ~dnh) | (dh & m_hi);
    sl_n = (m_sl & ~dnl) | (dl & m_lo);
    act_q = m_sh | m_sl;
    act_n = sh_n | sl_n;
    lat_n = (act_q & ~act_n) ? 1'b1 : (clr && !act_q) ? 1'b0 : m_lat;
    blk_n = uvf ? 1'b1 : (hr && !m_hq) ? 1'b0 : m_blk;
    ext = ~fs & ~m_fd;
    h_n = 0; l_n = 0;
    if (act_n) begin s = 6; h_n = sh_n ? 1'b0 : m_hi; l_n = sl_n ? 1'b0 : m_lo; end
    else if (lat_n) s = 5;
    else if (uvl) s = 4;
    else if (ext) s = 3;
    else if (!ss) begin s = 2; h_n = m_hi; l_n = m_lo; end
    else if (uvf) begin s = 1; l_n = lr; end
    else begin s = 0; h_n = hr & ~lr & ~blk_n; l_n = lr & ~hr; end
    m_fd = lat_n | (uvl & ~act_n);
    m_hi = h_n; m_lo = l_n; m_sh = sh_n; m_sl = sl_n;
    m_lat = lat_n; m_blk = blk_n; m_hq = hr; m_st = s;
  endtask

  task automatic cmp_all();
    string t;
    t = st_tag(m_st);
    chk(hi_on == m_hi, {t, " hi_on"}, hi_on, m_hi);
    chk(lo_on == m_lo, {t, " lo_on"}, lo_on, m_lo);
    chk(ssd_hi == m_sh && ssd_lo == m_sl, "R2 ssd flags", {ssd_hi, ssd_lo}, {m_sh, m_sl});
    chk(sync_drv == (m_sh | m_sl), "R3 sync drive", sync_drv, m_sh | m_sl);
    chk(flt_drv == m_fd, "R4/R7 fault drive", flt_drv, m_fd);
    chk(int'(st) == m_st, "R13 state code", st, m_st);
  endtask

  task automatic step(input logic h, l, d_h, d_l, n_h, n_l, u_l, u_f, c, s_x, f_x);
    hr = h; lr = l; dh = d_h; dl = d_l; dnh = n_h; dnl = n_l;
    uvl = u_l; uvf = u_f; clr = c; xs = s_x; xf = f_x;
    mstep();
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(24680);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all();
    chk(hi_on == 0 && lo_on == 0 && flt_drv == 0 && st == 0, "R13 reset state", st, 0);

    // R1 normal and anti-shoot-through
    step(1,0, 0,0,0,0, 0,0,0,0,0); chk(hi_on == 1, "R1 hi follows", hi_on, 1);
    step(1,1, 0,0,0,0, 0,0,0,0,0); chk(!hi_on && !lo_on, "R1 both requested", {hi_on,lo_on}, 0);
    step(0,0, 0,1,0,0, 0,0,0,0,0); chk(!ssd_lo, "R2 desat on off channel ignored", ssd_lo, 0);
    // R2 desat, R9 masking, R3 release, R4 latch and clear
    step(1,0, 0,0,0,0, 0,0,0,0,0);
    step(1,0, 1,0,0,0, 0,0,0,0,0);
    chk(ssd_hi && !hi_on && sync_drv && st == 6, "R2 enter ssd", st, 6);
    step(0,1, 0,0,0,0, 1,0,0,0,1);
    chk(!lo_on && !flt_drv && st == 6, "R9 masked during ssd", {lo_on,flt_drv}, 0);
    step(0,1, 0,0,1,0, 0,0,0,0,0);
    chk(!sync_drv && flt_drv && st == 5, "R3 sync released, R4 latched", {sync_drv,flt_drv}, 1);
    step(0,1, 0,0,0,0, 0,0,0,0,0); chk(!lo_on && st == 5, "R4 held low", lo_on, 0);
    step(0,1, 0,0,0,0, 0,0,1,0,0);
    chk(lo_on && !flt_drv && st == 0, "R4 cleared", lo_on, 1);
    // R5 freeze, R6 desat under freeze
    step(1,0, 0,0,0,0, 0,0,0,0,0);
    step(0,1, 0,0,0,0, 0,0,0,1,0);
    chk(hi_on && !lo_on && st == 2, "R5 frozen", {hi_on,lo_on}, 2);
    step(0,1, 1,0,0,0, 0,0,0,1,0);
    chk(ssd_hi && !hi_on && st == 6, "R6 desat in freeze", st, 6);
    step(0,0, 0,0,1,0, 0,0,0,1,0); chk(st == 5, "R4 latched after freeze ssd", st, 5);
    step(0,0, 0,0,0,0, 0,0,1,0,0); chk(st == 0, "R4 clear", st, 0);
    // R7 low-side uv, R12 own drive
    step(0,1, 0,0,0,0, 1,0,0,0,0);
    chk(flt_drv && !lo_on && st == 4, "R7 low uv", st, 4);
    step(0,1, 0,0,0,0, 0,0,0,0,0);
    chk(lo_on && st == 0, "R12 own drive not external", st, 0);
    step(0,1, 0,0,0,0, 0,0,0,0,0); chk(!flt_drv, "R7 not latched", flt_drv, 0);
    // R8 external shutdown not cleared by clear
    step(0,1, 0,0,0,0, 0,0,1,0,1);
    chk(!lo_on && !flt_drv && st == 3, "R8 ext shutdown", st, 3);
    step(0,1, 0,0,0,0, 0,0,0,0,0); chk(lo_on, "R8 not latched", lo_on, 1);
    // R10 floating uv, R11 rearm
    step(1,1, 0,0,0,0, 0,1,0,0,0);
    chk(!hi_on && lo_on && !flt_drv && st == 1, "R10 float uv", {hi_on,lo_on}, 1);
    step(1,0, 0,0,0,0, 0,0,0,0,0); chk(!hi_on, "R11 no edge yet", hi_on, 0);
    step(0,0, 0,0,0,0, 0,0,0,0,0);
    step(1,0, 0,0,0,0, 0,0,0,0,0); chk(hi_on, "R11 fresh edge", hi_on, 1);

    // seeded random phase
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0,1), $urandom_range(0,1),
           $urandom_range(0,7) == 0, $urandom_range(0,7) == 0,
           $urandom_range(0,5) == 0, $urandom_range(0,5) == 0,
           $urandom_range(0,19) == 0, $urandom_range(0,14) == 0,
           $urandom_range(0,5) == 0, $urandom_range(0,11) == 0,
           $urandom_range(0,14) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule